// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block holds wall-clock time and date in packed BCD and advances it by one second whenever a single-cycle enable tick arrives. It tracks seconds, minutes and hours on a 24-hour dial, a weekday number, the day of the month, the month, a two-digit year and a century flag. Month lengths, including February in leap years, are corrected without help from software.

Software sets any field through a narrow load port that has a field selector, an 8-bit data byte and a write strobe. A sticky low-supply flag records that the supply dipped. An external fail input sets it, and only a write to the seconds field clears it. A hold input freezes every counter. It stands in for resetting the seconds divider during test.

Top module: `rtccal_top`

## Requirements
- R1: After reset every time and calendar field and the century bit read 0, and the low-supply flag reads 1.
- R2: Seconds and minutes count 00..59 in packed BCD (tens in bits above bit 3). A step at 59 returns to 00 and advances the next field.
- R3: Hours count 00..23. A step at 23:59:59 returns to 00:00:00 and advances the day of month and the weekday together.
- R4: The weekday is a 3-bit value that counts 0..6. A midnight step at 6 gives 0.
- R5: In months 04, 06, 09 and 11 the day after 30 is 01. In every other month except 02 the day after 31 is 01. Each such wrap advances the month. A loaded day at or beyond the month's last day also wraps to 01 on the next midnight.
- R6: February has 29 days when the BCD year is a multiple of 4 (year 00 included) and 28 days otherwise.
- R7: The month after 12 is 01 and advances the year. The year after 99 is 00 and inverts the century bit (0 means 20xx, 1 means 19xx).
- R8: Counters change only in a cycle where secTick is high. While holdCount is high they keep their value.
- R9: With wrEn high, wrData is loaded into the field chosen by wrSel: 0 seconds (bits 6:0, bit 7 is the low-supply flag), 1 minutes (6:0), 2 hours (5:0), 3 weekday (2:0), 4 day (5:0), 5 month (4:0, with bit 7 as the century bit), 6 year (7:0). A cycle with wrEn high performs no time step, even if secTick is high.
- R10: The low-supply flag is set in any cycle where supplyFail is high and otherwise keeps its value. It is cleared only by a seconds write with bit 7 at 0. If supplyFail is high in the same cycle as such a write, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| secTick | input | 1 | One-cycle strobe, once per second |
| holdCount | input | 1 | Freezes all counters |
| supplyFail | input | 1 | Sets the low-supply flag |
| wrEn | input | 1 | Load strobe |
| wrSel | input | 3 | Field selector for loads |
| wrData | input | 8 | Load data |
| secOut | output | 7 | Seconds, BCD |
| minOut | output | 7 | Minutes, BCD |
| hourOut | output | 6 | Hours, BCD |
| wdayOut | output | 3 | Weekday 0..6 |
| dayOut | output | 6 | Day of month, BCD |
| monOut | output | 5 | Month, BCD |
| centuryOut | output | 1 | Century bit |
| yearOut | output | 8 | Year, BCD |
| lowSupplyOut | output | 1 | Sticky low-supply flag |

## Verification
Two pairs of events can fall in the same cycle. A load can meet a second tick, and a fail pulse can meet a seconds write that clears the flag. The bench provokes the first pair by writing the minutes while the seconds stand at 59 and a tick is present. The expected outcome is the loaded minutes with the seconds unchanged. It provokes the second pair by raising supplyFail during a clearing write, and then expects the flag to be set. Random traffic mixes loads, ticks, holds and fail pulses freely, and a bench model computed in plain binary judges every cycle.

// File: rtl/rtccal_pkg.sv
package rtccal_pkg;
  localparam int FIELD_COUNT = 7;
  localparam int SEL_W       = $clog2(FIELD_COUNT);
  localparam int WEEK_DAYS   = 7;
  localparam int WDAY_W      = $clog2(WEEK_DAYS);

  localparam int SEL_SEC  = 0;
  localparam int SEL_MIN  = 1;
  localparam int SEL_HOUR = 2;
  localparam int SEL_WDAY = 3;
  localparam int SEL_DAY  = 4;
  localparam int SEL_MON  = 5;
  localparam int SEL_YEAR = 6;

  typedef struct packed {
    logic [FIELD_COUNT-1:0] load;
    logic stepSec;
    logic stepMin;
    logic stepHour;
    logic stepDay;
    logic stepMon;
    logic stepYear;
  } strobeT;

  typedef struct packed {
    logic sec;
    logic min;
    logic hour;
    logic day;
    logic mon;
  } endFlagsT;

  function automatic logic isLeapBcd(input logic [7:0] yr);
    logic [3:0] units;
    units = yr[3:0];
    if (yr[4]) return (units == 4'd2) || (units == 4'd6);
    return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
  endfunction

  function automatic logic [5:0] monthLastBcd(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtccal_bcdinc.sv
module rtccal_bcdinc #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] nxt
);
  localparam int TENS_W = W - 4;

  logic [TENS_W-1:0] tens;
  logic [3:0]        units;

  assign tens  = val[W-1:4];
  assign units = val[3:0];

  always_comb begin
    if (units == 4'd9) nxt = {tens + TENS_W'(1), 4'd0};
    else               nxt = {tens, units + 4'd1};
  end
endmodule

// File: rtl/rtccal_ctrl.sv
module rtccal_ctrl
  import rtccal_pkg::*;
(
  input  logic             secTick,
  input  logic             holdCount,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  endFlagsT         atEnd,
  output strobeT           strobe
);
  always_comb begin
    for (int i = 0; i < FIELD_COUNT; i++) begin
      strobe.load[i] = wrEn && (wrSel == SEL_W'(i));
    end
    strobe.stepSec  = secTick && !holdCount && !wrEn;
    strobe.stepMin  = strobe.stepSec  && atEnd.sec;
    strobe.stepHour = strobe.stepMin  && atEnd.min;
    strobe.stepDay  = strobe.stepHour && atEnd.hour;
    strobe.stepMon  = strobe.stepDay  && atEnd.day;
    strobe.stepYear = strobe.stepMon  && atEnd.mon;
  end
endmodule

// File: rtl/rtccal_dp.sv
module rtccal_dp
  import rtccal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyFail,
  input  logic [7:0]        wrData,
  input  strobeT            strobe,
  output endFlagsT          atEnd,
  output logic [6:0]        secR,
  output logic [6:0]        minR,
  output logic [5:0]        hourR,
  output logic [WDAY_W-1:0] wdayR,
  output logic [5:0]        dayR,
  output logic [4:0]        monR,
  output logic              cenR,
  output logic [7:0]        yearR,
  output logic              lowSupR
);
  localparam logic [WDAY_W-1:0] WDAY_LAST = WDAY_W'(WEEK_DAYS - 1);

  logic [6:0] secInc, minInc;
  logic [5:0] hourInc, dayInc, lastDay;
  logic [4:0] monInc;
  logic [7:0] yearInc;
  logic       yearEnd;

  rtccal_bcdinc #(.W(7)) incSec  (.val(secR),  .nxt(secInc));
  rtccal_bcdinc #(.W(7)) incMin  (.val(minR),  .nxt(minInc));
  rtccal_bcdinc #(.W(6)) incHour (.val(hourR), .nxt(hourInc));
  rtccal_bcdinc #(.W(6)) incDay  (.val(dayR),  .nxt(dayInc));
  rtccal_bcdinc #(.W(5)) incMon  (.val(monR),  .nxt(monInc));
  rtccal_bcdinc #(.W(8)) incYear (.val(yearR), .nxt(yearInc));

  assign lastDay   = monthLastBcd(monR, isLeapBcd(yearR));
  assign atEnd.sec  = (secR  == 7'h59);
  assign atEnd.min  = (minR  == 7'h59);
  assign atEnd.hour = (hourR == 6'h23);
  assign atEnd.day  = (dayR  >= lastDay);
  assign atEnd.mon  = (monR  == 5'h12);
  assign yearEnd    = (yearR == 8'h99);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secR    <= '0;
      minR    <= '0;
      hourR   <= '0;
      wdayR   <= '0;
      dayR    <= '0;
      monR    <= '0;
      cenR    <= 1'b0;
      yearR   <= '0;
      lowSupR <= 1'b1;
    end else begin
      if (strobe.load[SEL_SEC])   secR <= wrData[6:0];
      else if (strobe.stepSec)    secR <= atEnd.sec ? 7'h00 : secInc;

      if (strobe.load[SEL_MIN])   minR <= wrData[6:0];
      else if (strobe.stepMin)    minR <= atEnd.min ? 7'h00 : minInc;

      if (strobe.load[SEL_HOUR])  hourR <= wrData[5:0];
      else if (strobe.stepHour)   hourR <= atEnd.hour ? 6'h00 : hourInc;

      if (strobe.load[SEL_WDAY])  wdayR <= wrData[WDAY_W-1:0];
      else if (strobe.stepDay)    wdayR <= (wdayR == WDAY_LAST) ? '0 : wdayR + WDAY_W'(1);

      if (strobe.load[SEL_DAY])   dayR <= wrData[5:0];
      else if (strobe.stepDay)    dayR <= atEnd.day ? 6'h01 : dayInc;

      if (strobe.load[SEL_MON])   monR <= wrData[4:0];
      else if (strobe.stepMon)    monR <= atEnd.mon ? 5'h01 : monInc;

      if (strobe.load[SEL_MON])   cenR <= wrData[7];
      else if (strobe.stepYear && yearEnd) cenR <= ~cenR;

      if (strobe.load[SEL_YEAR])  yearR <= wrData;
      else if (strobe.stepYear)   yearR <= yearEnd ? 8'h00 : yearInc;

      lowSupR <= supplyFail | (strobe.load[SEL_SEC] ? wrData[7] : lowSupR);
    end
  end
endmodule

// File: rtl/rtccal_top.sv
module rtccal_top
  import rtccal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              holdCount,
  input  logic              supplyFail,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [7:0]        wrData,
  output logic [6:0]        secOut,
  output logic [6:0]        minOut,
  output logic [5:0]        hourOut,
  output logic [WDAY_W-1:0] wdayOut,
  output logic [5:0]        dayOut,
  output logic [4:0]        monOut,
  output logic              centuryOut,
  output logic [7:0]        yearOut,
  output logic              lowSupplyOut
);
  strobeT   strobe;
  endFlagsT atEnd;

  rtccal_ctrl ctrl (
    .secTick(secTick), .holdCount(holdCount), .wrEn(wrEn), .wrSel(wrSel),
    .atEnd(atEnd), .strobe(strobe)
  );

  rtccal_dp dp (
    .clk(clk), .rstN(rstN), .supplyFail(supplyFail), .wrData(wrData),
    .strobe(strobe), .atEnd(atEnd),
    .secR(secOut), .minR(minOut), .hourR(hourOut), .wdayR(wdayOut),
    .dayR(dayOut), .monR(monOut), .cenR(centuryOut), .yearR(yearOut),
    .lowSupR(lowSupplyOut)
  );
endmodule

// File: rtl/rtccal_chk.sv
module rtccal_chk (
  input logic       clk,
  input logic       rstN,
  input logic       secTick,
  input logic       holdCount,
  input logic       supplyFail,
  input logic       wrEn,
  input logic [2:0] wrSel,
  input logic [7:0] wrData,
  input logic [6:0] secOut,
  input logic [6:0] minOut,
  input logic [5:0] hourOut,
  input logic [2:0] wdayOut,
  input logic [5:0] dayOut,
  input logic [4:0] monOut,
  input logic       centuryOut,
  input logic [7:0] yearOut,
  input logic       lowSupplyOut
);
  logic stepping;
  assign stepping = secTick && !holdCount && !wrEn;

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && secOut == 7'h59) |=> (secOut == 7'h00));

  // R4
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && wdayOut == 3'd6 && hourOut == 6'h23 && minOut == 7'h59 && secOut == 7'h59)
      |=> (wdayOut == 3'd0));

  // R7
  century_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && yearOut == 8'h99 && monOut == 5'h12 && dayOut == 6'h31 &&
     hourOut == 6'h23 && minOut == 7'h59 && secOut == 7'h59)
      |=> (centuryOut != $past(centuryOut) && yearOut == 8'h00 && monOut == 5'h01));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdCount && !wrEn) |=> ($stable(secOut) && $stable(minOut) && $stable(hourOut) &&
      $stable(wdayOut) && $stable(dayOut) && $stable(monOut) && $stable(yearOut) &&
      $stable(centuryOut)));

  // R9
  write_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd0) |=> (secOut == $past(wrData[6:0])));

  // R9
  write_century_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd5) |=> (centuryOut == $past(wrData[7])));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    supplyFail |=> lowSupplyOut);

  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyFail && !(wrEn && wrSel == 3'd0)) |=> $stable(lowSupplyOut));
endmodule

bind rtccal_top rtccal_chk chk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .holdCount(holdCount),
  .supplyFail(supplyFail), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .wdayOut(wdayOut),
  .dayOut(dayOut), .monOut(monOut), .centuryOut(centuryOut), .yearOut(yearOut),
  .lowSupplyOut(lowSupplyOut)
);

// File: tb/rtccal_top_test.sv
module rtccal_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0, holdCount = 1'b0, supplyFail = 1'b0, wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [6:0] secOut, minOut;
  logic [5:0] hourOut, dayOut;
  logic [2:0] wdayOut;
  logic [4:0] monOut;
  logic       centuryOut, lowSupplyOut;
  logic [7:0] yearOut;

  int checks = 0, fails = 0;
  bit done = 0;
  int ms = 0, mm = 0, mh = 0, mwd = 0, md = 0, mmo = 0, my = 0;
  bit mcen = 0, mflag = 1;

  always #2 clk = ~clk;

  rtccal_top uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .holdCount(holdCount),
    .supplyFail(supplyFail), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .wdayOut(wdayOut),
    .dayOut(dayOut), .monOut(monOut), .centuryOut(centuryOut), .yearOut(yearOut),
    .lowSupplyOut(lowSupplyOut)
  );

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int fromBcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int monthDays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelEdge(input bit tick, input bit hold, input bit fail, input bit we,
                           input logic [2:0] sel, input logic [7:0] data);
    bit newFlag;
    newFlag = (we && sel == 3'd0) ? data[7] : mflag;
    if (fail) newFlag = 1'b1;
    if (we) begin
      case (sel)
        3'd0: ms  = fromBcd({1'b0, data[6:0]});
        3'd1: mm  = fromBcd({1'b0, data[6:0]});
        3'd2: mh  = fromBcd({2'b0, data[5:0]});
        3'd3: mwd = int'(data[2:0]);
        3'd4: md  = fromBcd({2'b0, data[5:0]});
        3'd5: begin mmo = fromBcd({3'b0, data[4:0]}); mcen = data[7]; end
        3'd6: my  = fromBcd(data);
        default: ;
      endcase
    end else if (tick && !hold) begin
      ms++;
      if (ms == 60) begin
        ms = 0; mm++;
        if (mm == 60) begin
          mm = 0; mh++;
          if (mh == 24) begin
            mh = 0;
            mwd = (mwd + 1) % 7;
            if (md >= monthDays(mmo, my)) begin
              md = 1;
              if (mmo == 12) begin
                mmo = 1; my++;
                if (my == 100) begin my = 0; mcen = ~mcen; end
              end else mmo++;
            end else md++;
          end
        end
      end
    end
    mflag = newFlag;
  endtask

  task automatic compare(input string tag);
    logic [50:0] act, exp;
    act = {lowSupplyOut, centuryOut, yearOut, monOut, dayOut, wdayOut, hourOut, minOut, secOut};
    exp = {mflag, mcen, toBcd(my), toBcd(mmo)[4:0], toBcd(md)[5:0], 3'(mwd),
           toBcd(mh)[5:0], toBcd(mm)[6:0], toBcd(ms)[6:0]};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (flag,cen,yr,mo,day,wd,hr,min,sec)", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit tick, input bit hold, input bit fail, input bit we,
                     input logic [2:0] sel, input logic [7:0] data, input string tag);
    secTick = tick; holdCount = hold; supplyFail = fail;
    wrEn = we; wrSel = sel; wrData = data;
    @(posedge clk);
    modelEdge(tick, hold, fail, we, sel, data);
    @(negedge clk);
    compare(tag);
    secTick = 0; holdCount = 0; supplyFail = 0; wrEn = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    cyc(0, 0, 0, 1, sel, data, "R9 load");
  endtask

  task automatic setAll(input int h, input int mi, input int s, input int wd, input int d,
                        input int mo, input int yr, input bit cen);
    wr(3'd0, {1'b0, toBcd(s)[6:0]});
    wr(3'd1, {1'b0, toBcd(mi)[6:0]});
    wr(3'd2, toBcd(h));
    wr(3'd3, 8'(wd));
    wr(3'd4, toBcd(d));
    wr(3'd5, {cen, 2'b0, toBcd(mo)[4:0]});
    wr(3'd6, toBcd(yr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    @(negedge clk);
    compare("R1 reset state held");
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 3'd0, 8'h00, "R8 idle after reset");

    // R2/R3: minute and hour carries; R4 weekday 6 to 0; R6 leap February
    setAll(23, 59, 58, 6, 28, 2, 24, 0);
    cyc(1, 0, 0, 0, 0, 0, "R2 seconds step");
    cyc(1, 0, 0, 0, 0, 0, "R6 leap Feb 29 / R4 / R3");
    setAll(23, 59, 59, 2, 29, 2, 24, 0);
    cyc(1, 0, 0, 0, 0, 0, "R6 leap Feb 29 to Mar 1");
    setAll(23, 59, 59, 2, 28, 2, 23, 0);
    cyc(1, 0, 0, 0, 0, 0, "R6 common Feb 28 to Mar 1");
    setAll(23, 59, 59, 2, 28, 2, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, "R6 year 00 is leap");
    // R5 month lengths
    setAll(23, 59, 59, 3, 30, 4, 15, 0);
    cyc(1, 0, 0, 0, 0, 0, "R5 Apr 30 to May 1");
    setAll(23, 59, 59, 3, 30, 11, 15, 0);
    cyc(1, 0, 0, 0, 0, 0, "R5 Nov 30 to Dec 1");
    setAll(23, 59, 59, 3, 30, 1, 15, 0);
    cyc(1, 0, 0, 0, 0, 0, "R5 Jan 30 to Jan 31");
    cyc(0, 0, 0, 0, 0, 0, "R8 no tick no change");
    setAll(23, 59, 59, 3, 31, 6, 15, 0);
    cyc(1, 0, 0, 0, 0, 0, "R5 over-range day wraps");
    // R7 year and century
    setAll(23, 59, 59, 5, 31, 12, 99, 0);
    cyc(1, 0, 0, 0, 0, 0, "R7 year 99 to 00 century flips");
    setAll(23, 59, 59, 5, 31, 12, 99, 1);
    cyc(1, 0, 0, 0, 0, 0, "R7 century flips back");
    setAll(23, 59, 59, 5, 31, 12, 41, 0);
    cyc(1, 0, 0, 0, 0, 0, "R7 December to January");
    // R8 hold
    setAll(10, 59, 59, 1, 5, 5, 5, 0);
    cyc(1, 1, 0, 0, 0, 0, "R8 hold blocks tick");
    cyc(1, 0, 0, 0, 0, 0, "R2 minute carry after hold");
    // R9 write wins over tick
    wr(3'd0, 8'h59);
    cyc(1, 0, 0, 1, 3'd1, 8'h10, "R9 write suppresses step");
    // R10 flag behaviour
    wr(3'd0, 8'h05);
    cyc(0, 0, 1, 0, 0, 0, "R10 fail sets flag");
    cyc(0, 0, 0, 0, 0, 0, "R10 flag sticky");
    cyc(0, 0, 1, 1, 3'd0, 8'h07, "R10 fail beats clearing write");
    wr(3'd0, 8'h07);
    cyc(1, 0, 0, 1, 3'd2, 8'h08, "R10 other write leaves flag");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r, sel;
      logic [7:0] d;
      r = int'($urandom % 100);
      if (r < 72) begin
        cyc(1, (r < 6), (r % 17 == 0), 0, 0, 0, "R2 R3 R8 R10 random step");
      end else if (r < 92) begin
        sel = int'($urandom % 7);
        case (sel)
          0: d = {1'($urandom), (($urandom % 3) == 0) ? 7'h59 : toBcd(int'($urandom % 60))[6:0]};
          1: d = {1'b0, (($urandom % 2) == 0) ? 7'h59 : toBcd(int'($urandom % 60))[6:0]};
          2: d = (($urandom % 2) == 0) ? 8'h23 : toBcd(int'($urandom % 24));
          3: d = 8'($urandom % 7);
          4: d = toBcd(((($urandom % 2) == 0) ? 28 : 1) + int'($urandom % 4) * (((($urandom % 2) == 0)) ? 1 : 7));
          5: d = {1'($urandom), 2'b0, toBcd(1 + int'($urandom % 12))[4:0]};
          default: d = (($urandom % 3) == 0) ? 8'h99 : toBcd(int'($urandom % 100));
        endcase
        cyc(($urandom % 2) == 1, 0, (r == 91), 1, 3'(sel), d, "R9 R10 random load");
      end else begin
        cyc(0, (r > 96), 0, 0, 0, 0, "R8 random idle");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule